// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits beside the instruction pipeline of a 32-bit core. It owns the current status word. Every clock it looks at seven level-sensitive exception requests and drops the interrupt and fast interrupt when the status word disables them. It then picks the single winner by fixed priority. In the next cycle it raises a one-clock entry pulse with these values:

- the vector address;
- the new mode;
- the status word to be stored into the target mode's saved-status register;
- the link-register value.

On that same edge the current status word is rebuilt for the handler: the mode is forced, the interrupts are masked and the state switches to 32-bit.

The block also serves exception return. A return strobe copies a saved status word from the register file back into the current status word, which brings back the earlier execution state. The pipeline can also load the status word directly. When an exception entry, a return and a direct write fall in the same cycle, entry wins over return and return wins over the write.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Among active requests, the winner is chosen by this fixed priority, highest first: reset request, data abort, fast interrupt, interrupt, prefetch abort, undefined instruction, software interrupt. The last two never arrive together. An entry raises `take_o` for exactly one clock, in the cycle after the edge that sampled the requests.
- R2: `vec_o` gives the winner's vector: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C.
- R3: `mode_o` gives the target mode encoding:
  - supervisor 5'b10011 for reset request and software interrupt;
  - abort 5'b10111 for both aborts;
  - undefined 5'b11011 for undefined instruction;
  - interrupt 5'b10010;
  - fast interrupt 5'b10001.
- R4: On entry, `saved_sw_o` equals the status word held just before the entry.
- R5: On entry, the status word is rebuilt as follows:
  - bits 31:8 are kept;
  - bit 7 (interrupt disable) is set;
  - bit 6 (fast-interrupt disable) is set for reset request and fast interrupt and kept otherwise;
  - bit 5 (state, 1 = 16-bit) is cleared;
  - bits 4:0 take the target mode.
- R6: The value of `link_o` depends on the exception and, for two of them, on the state bit 5 that held before entry:

  | Exception | Value of `link_o` |
  |---|---|
  | Data abort | `pc_i`+8 |
  | Fast interrupt, interrupt, prefetch abort | `pc_i`+4 |
  | Undefined instruction, software interrupt | `pc_i`+4 when bit 5 was 0, `pc_i`+2 when it was 1 |
  | Reset request | 0 |

- R7: An interrupt request is ignored while status bit 7 is set, and a fast-interrupt request is ignored while bit 6 is set. A lower-priority request then wins as if the masked one were absent.
- R8: `ret_i` with no entry in the same cycle loads `saved_sw_i` into the status word on the next edge, restoring its state bit.
- R9: Synchronous `rst` sets the status word to 0x000000D3 (supervisor, both interrupts disabled, 32-bit state) and clears `take_o`, `vec_o`, `mode_o`, `saved_sw_o` and `link_o`.
- R10: `sw_wr_i` loads `sw_wdata_i` into the status word only when neither an entry nor a return occurs in that cycle. Entry takes precedence over return.
- R11: In cycles without an entry, `vec_o`, `mode_o`, `saved_sw_o` and `link_o` hold the values of the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_exc_i | input | 1 | Reset exception request |
| dabt_req_i | input | 1 | Data abort request |
| fiq_req_i | input | 1 | Fast interrupt request |
| irq_req_i | input | 1 | Interrupt request |
| pabt_req_i | input | 1 | Prefetch abort request |
| und_req_i | input | 1 | Undefined instruction request |
| swi_req_i | input | 1 | Software interrupt request |
| pc_i | input | 32 | PC of the current instruction |
| ret_i | input | 1 | Exception return strobe |
| saved_sw_i | input | 32 | Saved status word to restore on return |
| sw_wr_i | input | 1 | Direct status word write strobe |
| sw_wdata_i | input | 32 | Direct status word write data |
| take_o | output | 1 | One-cycle entry pulse |
| vec_o | output | 32 | Vector address of the entry |
| mode_o | output | 5 | Target mode of the entry |
| saved_sw_o | output | 32 | Status word to store in the saved-status register |
| link_o | output | 32 | Link register value |
| status_o | output | 32 | Current status word |

## Verification
The same cycle can carry three kinds of status-word update: an exception entry, a return strobe, and a direct write. It can also carry several competing requests, some of them masked by the very status word that is about to change. The bench provokes these collisions in two ways:
- directed cycles that raise a prefetch abort together with `ret_i`, and `ret_i` together with `sw_wr_i`;
- a long random phase where every strobe and request fires independently.

A behavioural model applies the R10 precedence and the R7 masking from its own state and is compared against every output on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int WORD_W      = 32;
    localparam int MODE_W      = 5;
    localparam int VEC_W       = 8;
    localparam int OFF_W       = 4;
    localparam int NUM_EXC     = 7;
    localparam int KIND_W      = $clog2(NUM_EXC);

    localparam int BIT_IRQ_OFF = 7;
    localparam int BIT_FIQ_OFF = 6;
    localparam int BIT_STATE   = 5;

    localparam logic [WORD_W-1:0] SW_RESET = 32'h0000_00D3;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    // Index equals priority rank: 0 is the highest.
    typedef enum logic [KIND_W-1:0] {
        EX_RST  = 3'd0,
        EX_DABT = 3'd1,
        EX_FIQ  = 3'd2,
        EX_IRQ  = 3'd3,
        EX_PABT = 3'd4,
        EX_UND  = 3'd5,
        EX_SWI  = 3'd6
    } exc_e;

    typedef struct packed {
        logic [WORD_W-1:0] vec;
        mode_e             mode;
        logic [WORD_W-1:0] sw_new;
        logic [WORD_W-1:0] link;
    } entry_t;

    function automatic logic [VEC_W-1:0] vector_of(exc_e k);
        case (k)
            EX_RST:  return 8'h00;
            EX_UND:  return 8'h04;
            EX_SWI:  return 8'h08;
            EX_PABT: return 8'h0C;
            EX_DABT: return 8'h10;
            EX_IRQ:  return 8'h18;
            default: return 8'h1C;
        endcase
    endfunction

    function automatic mode_e mode_of(exc_e k);
        case (k)
            EX_RST, EX_SWI:   return MODE_SVC;
            EX_DABT, EX_PABT: return MODE_ABT;
            EX_UND:           return MODE_UND;
            EX_IRQ:           return MODE_IRQ;
            default:          return MODE_FIQ;
        endcase
    endfunction

    // Offset from the current PC; the two instruction-decoded exceptions
    // step by the instruction size, which is halved in 16-bit state.
    function automatic logic [OFF_W-1:0] link_offset(exc_e k, logic narrow);
        case (k)
            EX_RST:          return 4'd0;
            EX_DABT:         return 4'd8;
            EX_UND, EX_SWI:  return narrow ? 4'd2 : 4'd4;
            default:         return 4'd4;
        endcase
    endfunction

    function automatic logic sets_fiq_off(exc_e k);
        return (k == EX_RST) || (k == EX_FIQ);
    endfunction

endpackage

// File: rtl/exc_req_mask.sv
module exc_req_mask
    import exc_pkg::*;
(
    input  logic              reset_exc_i,
    input  logic              dabt_req_i,
    input  logic              fiq_req_i,
    input  logic              irq_req_i,
    input  logic              pabt_req_i,
    input  logic              und_req_i,
    input  logic              swi_req_i,
    input  logic [WORD_W-1:0] sw_i,
    output logic [NUM_EXC-1:0] req_o
);
    always_comb begin
        req_o          = '0;
        req_o[EX_RST]  = reset_exc_i;
        req_o[EX_DABT] = dabt_req_i;
        req_o[EX_FIQ]  = fiq_req_i & ~sw_i[BIT_FIQ_OFF];
        req_o[EX_IRQ]  = irq_req_i & ~sw_i[BIT_IRQ_OFF];
        req_o[EX_PABT] = pabt_req_i;
        req_o[EX_UND]  = und_req_i;
        req_o[EX_SWI]  = swi_req_i;
    end
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
    parameter int N     = 7,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     gnt_o,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_rank
            if (g == 0) begin : g_top
                assign gnt_o[g] = req_i[g];
            end else begin : g_lower
                assign gnt_o[g] = req_i[g] & ~(|req_i[g-1:0]);
            end
        end
    endgenerate

    assign any_o = |req_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_o[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/exc_entry_build.sv
module exc_entry_build
    import exc_pkg::*;
(
    input  exc_e              kind_i,
    input  logic [WORD_W-1:0] sw_i,
    input  logic [WORD_W-1:0] pc_i,
    output entry_t            ent_o
);
    always_comb begin
        ent_o.vec    = WORD_W'(vector_of(kind_i));
        ent_o.mode   = mode_of(kind_i);
        ent_o.sw_new = sw_i;
        ent_o.sw_new[BIT_IRQ_OFF] = 1'b1;
        if (sets_fiq_off(kind_i)) ent_o.sw_new[BIT_FIQ_OFF] = 1'b1;
        ent_o.sw_new[BIT_STATE] = 1'b0;
        ent_o.sw_new[MODE_W-1:0] = ent_o.mode;
        if (kind_i == EX_RST)
            ent_o.link = '0;
        else
            ent_o.link = pc_i + WORD_W'(link_offset(kind_i, sw_i[BIT_STATE]));
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reset_exc_i,
    input  logic              dabt_req_i,
    input  logic              fiq_req_i,
    input  logic              irq_req_i,
    input  logic              pabt_req_i,
    input  logic              und_req_i,
    input  logic              swi_req_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic              ret_i,
    input  logic [WORD_W-1:0] saved_sw_i,
    input  logic              sw_wr_i,
    input  logic [WORD_W-1:0] sw_wdata_i,
    output logic              take_o,
    output logic [WORD_W-1:0] vec_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [WORD_W-1:0] saved_sw_o,
    output logic [WORD_W-1:0] link_o,
    output logic [WORD_W-1:0] status_o
);
    logic [NUM_EXC-1:0] live_req;
    logic [NUM_EXC-1:0] gnt;
    logic               win_any;
    logic [KIND_W-1:0]  win_idx;
    entry_t             ent;
    logic [WORD_W-1:0]  sw_q;

    exc_req_mask u_mask (
        .reset_exc_i (reset_exc_i),
        .dabt_req_i  (dabt_req_i),
        .fiq_req_i   (fiq_req_i),
        .irq_req_i   (irq_req_i),
        .pabt_req_i  (pabt_req_i),
        .und_req_i   (und_req_i),
        .swi_req_i   (swi_req_i),
        .sw_i        (sw_q),
        .req_o       (live_req)
    );

    exc_prio_arb #(.N(NUM_EXC)) u_arb (
        .req_i (live_req),
        .gnt_o (gnt),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    exc_entry_build u_build (
        .kind_i (exc_e'(win_idx)),
        .sw_i   (sw_q),
        .pc_i   (pc_i),
        .ent_o  (ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q       <= SW_RESET;
            take_o     <= 1'b0;
            vec_o      <= '0;
            mode_o     <= '0;
            saved_sw_o <= '0;
            link_o     <= '0;
        end else begin
            take_o <= win_any;
            if (win_any) begin
                vec_o      <= ent.vec;
                mode_o     <= ent.mode;
                saved_sw_o <= sw_q;
                link_o     <= ent.link;
                sw_q       <= ent.sw_new;
            end else if (ret_i) begin
                sw_q <= saved_sw_i;
            end else if (sw_wr_i) begin
                sw_q <= sw_wdata_i;
            end
        end
    end

    assign status_o = sw_q;

    // R1: at most one grant; R1 environment: decode-exclusive requests
    a_r1_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    a_r1_und_swi_excl: assert property (@(posedge clk) disable iff (rst)
        !(und_req_i && swi_req_i));
    // R1/R2: reset request always wins and vectors to zero
    a_r2_reset_wins: assert property (@(posedge clk) disable iff (rst)
        reset_exc_i |=> (take_o && vec_o == '0 && mode_o == MODE_SVC));
    // R4: saved copy is the pre-entry status word
    a_r4_saved_copy: assert property (@(posedge clk) disable iff (rst)
        take_o |-> saved_sw_o == $past(sw_q));
    // R5: handler status word is masked, 32-bit, and in the target mode
    a_r5_entry_status: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (sw_q[BIT_IRQ_OFF] && !sw_q[BIT_STATE] && sw_q[MODE_W-1:0] == mode_o));
    // R7: a masked interrupt alone never causes an entry
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (sw_q[BIT_IRQ_OFF] && irq_req_i && !reset_exc_i && !dabt_req_i &&
         !(fiq_req_i && !sw_q[BIT_FIQ_OFF]) && !pabt_req_i && !und_req_i && !swi_req_i)
        |=> !take_o);
    // R8: a return without entry restores the saved word
    a_r8_return: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !win_any) |=> sw_q == $past(saved_sw_i));
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_exc_i = 0, dabt_req_i = 0, fiq_req_i = 0, irq_req_i = 0;
    logic        pabt_req_i = 0, und_req_i = 0, swi_req_i = 0;
    logic [31:0] pc_i = 0;
    logic        ret_i = 0;
    logic [31:0] saved_sw_i = 0;
    logic        sw_wr_i = 0;
    logic [31:0] sw_wdata_i = 0;
    logic        take_o;
    logic [31:0] vec_o, saved_sw_o, link_o, status_o;
    logic [4:0]  mode_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_sw, m_vec, m_saved, m_link;
    logic [4:0]  m_mode;
    logic        m_take;

    always #2 clk = ~clk;

    exc_entry_ctrl uut (.*);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic ref_update();
        int k;
        logic fiq_ok, irq_ok, narrow;
        if (rst) begin
            m_sw = 32'hD3; m_take = 0; m_vec = 0; m_mode = 0; m_saved = 0; m_link = 0;
            return;
        end
        fiq_ok = fiq_req_i && !m_sw[6];
        irq_ok = irq_req_i && !m_sw[7];
        narrow = m_sw[5];
        if (reset_exc_i)     k = 0;
        else if (dabt_req_i) k = 1;
        else if (fiq_ok)     k = 2;
        else if (irq_ok)     k = 3;
        else if (pabt_req_i) k = 4;
        else if (und_req_i)  k = 5;
        else if (swi_req_i)  k = 6;
        else                 k = -1;
        m_take = (k >= 0);
        if (k >= 0) begin
            case (k)
                0: begin m_vec = 'h00; m_mode = 5'b10011; m_link = 0; end
                1: begin m_vec = 'h10; m_mode = 5'b10111; m_link = pc_i + 8; end
                2: begin m_vec = 'h1C; m_mode = 5'b10001; m_link = pc_i + 4; end
                3: begin m_vec = 'h18; m_mode = 5'b10010; m_link = pc_i + 4; end
                4: begin m_vec = 'h0C; m_mode = 5'b10111; m_link = pc_i + 4; end
                5: begin m_vec = 'h04; m_mode = 5'b11011; m_link = pc_i + (narrow ? 2 : 4); end
                default: begin m_vec = 'h08; m_mode = 5'b10011; m_link = pc_i + (narrow ? 2 : 4); end
            endcase
            m_saved = m_sw;
            m_sw = {m_sw[31:8], 1'b1, (m_sw[6] | (k == 0) | (k == 2)), 1'b0, m_mode};
        end else if (ret_i) m_sw = saved_sw_i;
        else if (sw_wr_i)   m_sw = sw_wdata_i;
    endtask

    task automatic step();
        @(posedge clk);
        ref_update();
        #1;
        chk("R1", "take", {31'd0, take_o}, {31'd0, m_take});
        chk("R2", "vec", vec_o, m_vec);
        chk("R3", "mode", {27'd0, mode_o}, {27'd0, m_mode});
        chk("R4", "saved", saved_sw_o, m_saved);
        chk("R5/R8/R10", "status", status_o, m_sw);
        chk("R6", "link", link_o, m_link);
    endtask

    task automatic idle();
        reset_exc_i = 0; dabt_req_i = 0; fiq_req_i = 0; irq_req_i = 0;
        pabt_req_i = 0; und_req_i = 0; swi_req_i = 0; ret_i = 0; sw_wr_i = 0;
    endtask

    task automatic load_sw(logic [31:0] v);
        idle(); sw_wr_i = 1; sw_wdata_i = v; step(); idle();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        rst = 1; step(); step();
        chk("R9", "reset status", status_o, 32'h0000_00D3);
        chk("R9", "reset take", {31'd0, take_o}, 32'd0);
        chk("R9", "reset link", link_o, 32'd0);
        rst = 0; idle(); step();

        // R1: everything at once, reset request wins
        load_sw(32'hF000_0010);
        pc_i = 32'h1000;
        reset_exc_i = 1; dabt_req_i = 1; fiq_req_i = 1; irq_req_i = 1; pabt_req_i = 1; und_req_i = 1;
        step(); idle();
        chk("R1", "reset wins vec", vec_o, 32'h00);
        chk("R5", "reset status", status_o, 32'hF000_00D3);
        chk("R6", "reset link", link_o, 32'h0);

        // R1/R6: data abort over fast interrupt and interrupt, link +8
        load_sw(32'hF000_0010);
        dabt_req_i = 1; fiq_req_i = 1; irq_req_i = 1; step(); idle();
        chk("R2", "dabt vec", vec_o, 32'h10);
        chk("R6", "dabt link", link_o, 32'h1008);
        chk("R5", "dabt status", status_o, 32'hF000_0097);

        // R5: fast interrupt sets both masks
        load_sw(32'hF000_0010);
        fiq_req_i = 1; irq_req_i = 1; pabt_req_i = 1; step(); idle();
        chk("R2", "fiq vec", vec_o, 32'h1C);
        chk("R5", "fiq status", status_o, 32'hF000_00D1);

        // R5/R6: interrupt from 16-bit state, T cleared, link +4
        load_sw(32'h0000_0030);
        irq_req_i = 1; pabt_req_i = 1; step(); idle();
        chk("R6", "irq link", link_o, 32'h1004);
        chk("R5", "irq status", status_o, 32'h0000_0092);

        // R6: undefined in 16-bit state gives +2, software interrupt in 32-bit gives +4
        load_sw(32'h0000_0030);
        und_req_i = 1; step(); idle();
        chk("R6", "und thumb link", link_o, 32'h1002);
        chk("R3", "und mode", {27'd0, mode_o}, 32'h1B);
        load_sw(32'h0000_0010);
        swi_req_i = 1; step(); idle();
        chk("R6", "swi arm link", link_o, 32'h1004);
        chk("R3", "swi mode", {27'd0, mode_o}, 32'h13);

        // R7: masked interrupt yields to prefetch abort, alone yields nothing
        load_sw(32'h0000_0090);
        irq_req_i = 1; pabt_req_i = 1; step(); idle();
        chk("R7", "masked irq pabt vec", vec_o, 32'h0C);
        load_sw(32'h0000_0090);
        irq_req_i = 1; step(); idle();
        chk("R7", "masked irq no take", {31'd0, take_o}, 32'd0);
        chk("R7", "masked irq status", status_o, 32'h0000_0090);
        load_sw(32'h0000_0050);
        fiq_req_i = 1; step(); idle();
        chk("R7", "masked fiq no take", {31'd0, take_o}, 32'd0);

        // R8: return restores the saved word including T
        ret_i = 1; saved_sw_i = 32'h2000_0030; step(); idle();
        chk("R8", "return status", status_o, 32'h2000_0030);

        // R10: entry beats return in the same cycle
        load_sw(32'h0000_0010);
        pabt_req_i = 1; ret_i = 1; saved_sw_i = 32'h11; step(); idle();
        chk("R10", "entry over return", status_o, 32'h0000_0097);
        step();
        chk("R11", "vec held", vec_o, 32'h0C);
        chk("R11", "take low", {31'd0, take_o}, 32'd0);

        // R10: return beats a direct write
        sw_wr_i = 1; sw_wdata_i = 32'h1F; ret_i = 1; saved_sw_i = 32'h12; step(); idle();
        chk("R10", "return over write", status_o, 32'h12);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int u;
            rst         = ($urandom_range(0, 499) == 0);
            reset_exc_i = ($urandom_range(0, 39) == 0);
            dabt_req_i  = ($urandom_range(0, 9) == 0);
            fiq_req_i   = ($urandom_range(0, 7) == 0);
            irq_req_i   = ($urandom_range(0, 5) == 0);
            pabt_req_i  = ($urandom_range(0, 9) == 0);
            u           = $urandom_range(0, 11);
            und_req_i   = (u == 0);
            swi_req_i   = (u == 1);
            ret_i       = ($urandom_range(0, 5) == 0);
            saved_sw_i  = $urandom;
            sw_wr_i     = ($urandom_range(0, 4) == 0);
            sw_wdata_i  = $urandom;
            pc_i        = {$urandom, 2'b00} >> 2 << 2;
            step();
        end
        rst = 0; idle(); step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule